// File: doc/BRIEF.md
# Saturating Paired Partial-Sum Vector Unit

This block is one execution slice of a vector integer pipeline. Each cycle it can accept a 32-bit instruction word and two 128-bit operand vectors. Each vector holds four signed 32-bit word lanes. When the word decodes as the paired partial-sum operation, the block adds the two upper lanes of the first operand to an anchor word of the second operand, and does the same for the two lower lanes. Each sum is clamped to the signed 32-bit range. The two results go into the odd word lanes of a 128-bit result, and the even lanes are zero.

The result, the destination register index and a write enable are registered, so they appear one clock after the input. A sticky saturation flag records any clamp. Only reset or an explicit clear input lowers it. Register-file access, other opcodes and hazard handling are outside this block, so the operands arrive directly on the ports.

Top module: `psum_sat_unit`

## Requirements
- R1: An input is accepted only when `in_valid` is high and the instruction matches. Instruction bits [31:26] must equal 4 and bits [10:0] must equal 1672, so the word is 0x10000688 with the register fields zero. `wr_en` is high in the cycle after an accepted input and low after any other cycle.
- R2: `wr_idx` carries instruction bits [25:21] of the accepted input, one clock later.
- R3: Lanes are numbered big-endian: lane k of a vector is bits [127-32k : 96-32k]. Result lane 1 is the saturated value of A.lane0 + A.lane1 + B.lane1, with all operands signed.
- R4: Result lane 3 is the saturated value of A.lane2 + A.lane3 + B.lane3, with all operands signed.
- R5: Result lanes 0 and 2 are zero for every accepted input.
- R6: A sum above 0x7FFFFFFF gives 0x7FFFFFFF. This holds for each lane alone, for both lanes at once, and for three maximum operands.
- R7: A sum below -2^31 gives 0x80000000, including the worst case of three operands that are all 0x80000000. A sum of exactly 0x7FFFFFFF or exactly 0x80000000 passes through unchanged and does not count as saturation.
- R8: `sat_flag` rises one clock after an accepted input in which either sum saturated. It then stays high across later non-saturating operations.
- R9: When `sat_clear` is high, `sat_flag` is zero one clock later, even if a saturating operation is accepted in the same cycle.
- R10: A non-matching instruction, or a matching one with `in_valid` low, leaves `wr_en` low. It also leaves `wr_data`, `wr_idx` and `sat_flag` at their previous values.
- R11: After a synchronous reset, `wr_en`, `wr_idx`, `wr_data` and `sat_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| insn | input | 32 | Instruction word |
| src_a | input | 128 | First operand vector, lane 0 in the top bits |
| src_b | input | 128 | Second operand vector, supplies the anchor words |
| sat_clear | input | 1 | Synchronous clear of the sticky flag, takes priority over a set |
| wr_en | output | 1 | Result write enable, registered |
| wr_idx | output | 5 | Destination register index, registered |
| wr_data | output | 128 | Result vector, registered |
| sat_flag | output | 1 | Sticky saturation status |

## Verification
Every result (`wr_en`, `wr_idx`, `wr_data`) and every change to `sat_flag`, whether a set or a clear, is due exactly one rising edge after the inputs that cause it. The bench applies inputs on the falling edge. Its reference model advances at the next rising edge, using the inputs that are still stable then. The following falling edge is where the bench compares all four outputs against the model, so each check falls in the middle of the cycle in which the result first appears. Hold behaviour after ignored inputs is also checked at that point, because the model keeps its previous values.

// File: rtl/psum_pkg.sv
package psum_pkg;
  parameter int LANE_W   = 32;
  parameter int LANES    = 4;
  parameter int REG_W    = 5;
  parameter int INSN_W   = 32;
  parameter int PRIM_W   = 6;
  parameter int EXT_W    = 11;
  parameter logic [PRIM_W-1:0] PRIM_OP = 6'd4;
  parameter logic [EXT_W-1:0]  EXT_OP  = 11'd1672;

  localparam int VEC_W  = LANE_W * LANES;
  localparam int PAIRS  = LANES / 2;
  localparam int SUM_W  = LANE_W + 2;
  localparam int DST_LO = INSN_W - PRIM_W - REG_W;
endpackage

// File: rtl/psum_decode.sv
module psum_decode
  import psum_pkg::*;
(
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  output logic              hit,
  output logic [REG_W-1:0]  dst
);
  logic prim_ok;
  logic ext_ok;

  always_comb begin
    prim_ok = (insn[INSN_W-1 -: PRIM_W] == PRIM_OP);
    ext_ok  = (insn[EXT_W-1:0] == EXT_OP);
    hit     = in_valid && prim_ok && ext_ok;
    dst     = insn[DST_LO +: REG_W];
  end
endmodule

// File: rtl/psum_lane_adder.sv
module psum_lane_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  input  logic [W-1:0] op_z,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam int SW = W + 2;

  logic [SW-1:0] ext_x, ext_y, ext_z, total;
  logic          top_sign;
  logic [1:0]    guard;
  logic          over, under;

  always_comb begin
    ext_x    = {{2{op_x[W-1]}}, op_x};
    ext_y    = {{2{op_y[W-1]}}, op_y};
    ext_z    = {{2{op_z[W-1]}}, op_z};
    total    = ext_x + ext_y + ext_z;
    top_sign = total[SW-1];
    guard    = total[SW-2:SW-3];
    over     = !top_sign && ((guard != 2'b00) || total[W-1]);
    under    = top_sign && ((guard != 2'b11) || !total[W-1]);
    sat      = over || under;
    if (over)
      res = {1'b0, {(W-1){1'b1}}};
    else if (under)
      res = {1'b1, {(W-1){1'b0}}};
    else
      res = total[W-1:0];
  end
endmodule

// File: rtl/psum_sticky.sv
module psum_sticky (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (clr)
      flag <= 1'b0;
    else if (set)
      flag <= 1'b1;
  end
endmodule

// File: rtl/psum_sat_unit.sv
module psum_sat_unit
  import psum_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic              sat_clear,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_idx,
  output logic [VEC_W-1:0]  wr_data,
  output logic              sat_flag
);
  logic             hit;
  logic [REG_W-1:0] dst;
  logic [VEC_W-1:0] next_data;
  logic [PAIRS-1:0] pair_sat;

  psum_decode u_dec (
    .in_valid (in_valid),
    .insn     (insn),
    .hit      (hit),
    .dst      (dst)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int EVN = 2 * p;
    localparam int ODD = 2 * p + 1;
    localparam int EVN_HI = VEC_W - 1 - EVN * LANE_W;
    localparam int ODD_HI = VEC_W - 1 - ODD * LANE_W;

    logic [LANE_W-1:0] lane_res;

    psum_lane_adder #(.W(LANE_W)) u_add (
      .op_x (src_a[EVN_HI -: LANE_W]),
      .op_y (src_a[ODD_HI -: LANE_W]),
      .op_z (src_b[ODD_HI -: LANE_W]),
      .res  (lane_res),
      .sat  (pair_sat[p])
    );

    assign next_data[EVN_HI -: LANE_W] = '0;
    assign next_data[ODD_HI -: LANE_W] = lane_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= hit;
      if (hit) begin
        wr_idx  <= dst;
        wr_data <= next_data;
      end
    end
  end

  psum_sticky u_sticky (
    .clk  (clk),
    .rst  (rst),
    .clr  (sat_clear),
    .set  (hit && (|pair_sat)),
    .flag (sat_flag)
  );
endmodule

// File: rtl/psum_checker.sv
module psum_checker
  import psum_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [INSN_W-1:0] insn,
  input logic              sat_clear,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_idx,
  input logic [VEC_W-1:0]  wr_data,
  input logic              sat_flag
);
  logic port_hit;
  assign port_hit = in_valid && (insn[INSN_W-1 -: PRIM_W] == PRIM_OP)
                    && (insn[EXT_W-1:0] == EXT_OP);

  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    port_hit |=> wr_en);

  assert_reject_R10: assert property (@(posedge clk) disable iff (rst)
    !port_hit |=> !wr_en);

  assert_dst_R2: assert property (@(posedge clk) disable iff (rst)
    port_hit |=> (wr_idx == $past(insn[DST_LO +: REG_W])));

  assert_even_zero_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[VEC_W-1 -: LANE_W] == '0)
              && (wr_data[VEC_W-1-2*LANE_W -: LANE_W] == '0));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sat_clear) |=> sat_flag);

  assert_set_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_flag) |-> $past(port_hit));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    sat_clear |=> !sat_flag);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !port_hit |=> $stable(wr_data) && $stable(wr_idx));
endmodule

bind psum_sat_unit psum_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .insn      (insn),
  .sat_clear (sat_clear),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .sat_flag  (sat_flag)
);

// File: tb/psum_sat_unit_tb.sv
`timescale 1ns/1ps
module psum_sat_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [31:0]  insn;
  logic [127:0] src_a, src_b;
  logic         sat_clear;
  logic         wr_en;
  logic [4:0]   wr_idx;
  logic [127:0] wr_data;
  logic         sat_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model state
  logic         m_en   = 1'b0;
  logic [4:0]   m_idx  = '0;
  logic [127:0] m_data = '0;
  logic         m_sat  = 1'b0;

  always #4 clk = ~clk;

  psum_sat_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .src_a(src_a), .src_b(src_b), .sat_clear(sat_clear),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sat_flag(sat_flag)
  );

  function automatic logic [31:0] mk(input int d, input int ra, input int rb);
    logic [4:0] d5  = d[4:0];
    logic [4:0] a5  = ra[4:0];
    logic [4:0] b5  = rb[4:0];
    return {6'd4, d5, a5, b5, 11'd1672};
  endfunction

  function automatic longint sx(input logic [31:0] w);
    return longint'($signed(w));
  endfunction

  function automatic logic [31:0] clamp(input longint s);
    if (s > 64'sd2147483647) return 32'h7FFFFFFF;
    if (s < -64'sd2147483648) return 32'h80000000;
    return s[31:0];
  endfunction

  function automatic bit over(input longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  function automatic logic [127:0] vec(input logic [31:0] l0, input logic [31:0] l1,
                                       input logic [31:0] l2, input logic [31:0] l3);
    return {l0, l1, l2, l3};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare(input string dtag, input string stag);
    check(wr_en == m_en, "R1/R10 wr_en", 128'(wr_en), 128'(m_en));
    check(wr_idx == m_idx, "R2 wr_idx", 128'(wr_idx), 128'(m_idx));
    check(wr_data == m_data, dtag, wr_data, m_data);
    check(sat_flag == m_sat, stag, 128'(sat_flag), 128'(m_sat));
  endtask

  // drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input logic v, input logic [31:0] ins, input logic [127:0] a,
                      input logic [127:0] b, input logic clr,
                      input string dtag, input string stag);
    in_valid = v; insn = ins; src_a = a; src_b = b; sat_clear = clr;
    @(posedge clk);
    begin
      bit hit = v && (ins[31:26] == 6'd4) && (ins[10:0] == 11'd1672);
      longint s1 = sx(a[127:96]) + sx(a[95:64]) + sx(b[95:64]);
      longint s3 = sx(a[63:32]) + sx(a[31:0]) + sx(b[31:0]);
      m_en = hit;
      if (hit) begin
        m_idx  = ins[25:21];
        m_data = vec(32'h0, clamp(s1), 32'h0, clamp(s3));
      end
      if (clr) m_sat = 1'b0;
      else if (hit && (over(s1) || over(s3))) m_sat = 1'b1;
    end
    @(negedge clk);
    compare(dtag, stag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; insn = '0; src_a = '0; src_b = '0; sat_clear = 1'b0;
    repeat (3) @(negedge clk);
    compare("R11 reset data", "R11 reset sat");
    rst = 1'b0;

    // R3 R4 R5 plain sums
    step(1, mk(7, 1, 2), vec(32'd1, 32'd2, 32'd3, 32'd4),
         vec(32'd100, 32'd200, 32'd300, 32'd400), 0, "R3 R4 R5 basic", "R8 no sat");
    step(1, mk(31, 0, 0), vec(32'hFFFFFFF6, 32'd5, 32'h12345678, 32'hFFFFFFFF),
         vec(32'hDEADBEEF, 32'hFFFFFFFE, 32'hCAFEF00D, 32'd1), 0,
         "R3 R4 signed mix", "R8 no sat");
    // R7 exact boundaries, no saturation
    step(1, mk(3, 4, 5), vec(32'h7FFFFFFE, 32'd1, 32'h80000001, 32'hFFFFFFFF),
         vec(32'd9, 32'd0, 32'd9, 32'd0), 0, "R7 boundary exact", "R7 boundary no sat");
    // R10 ignored inputs
    step(1, 32'h10000689, vec(32'h7FFFFFFF, 32'h7FFFFFFF, 32'd0, 32'd0),
         vec(32'd0, 32'h7FFFFFFF, 32'd0, 32'd0), 0, "R10 wrong ext hold", "R10 sat unchanged");
    step(1, 32'h14000688, vec(32'h7FFFFFFF, 32'h7FFFFFFF, 32'd0, 32'd0),
         vec(32'd0, 32'h7FFFFFFF, 32'd0, 32'd0), 0, "R10 wrong prim hold", "R10 sat unchanged");
    step(0, mk(9, 0, 0), vec(32'h7FFFFFFF, 32'h7FFFFFFF, 32'd0, 32'd0),
         vec(32'd0, 32'h7FFFFFFF, 32'd0, 32'd0), 0, "R10 invalid hold", "R10 sat unchanged");
    // R6 positive sat lane 1 alone
    step(1, mk(1, 0, 0), vec(32'h7FFFFFFF, 32'd1, 32'd10, 32'd20),
         vec(32'd0, 32'd0, 32'd0, 32'd5), 0, "R6 pos sat lane1", "R8 set lane1");
    // R8 sticky across non-saturating ops
    step(1, mk(2, 0, 0), vec(32'd1, 32'd1, 32'd1, 32'd1), vec(32'd1, 32'd1, 32'd1, 32'd1), 0,
         "R3 after sat", "R8 sticky");
    step(1, mk(2, 0, 0), vec(32'd5, 32'd6, 32'd7, 32'd8), '0, 0, "R4 after sat", "R8 sticky");
    // R9 clear
    step(0, '0, '0, '0, 1, "R10 idle", "R9 clear");
    // R7 negative sat lane 3 alone
    step(1, mk(4, 0, 0), vec(32'd3, 32'd4, 32'h80000000, 32'hFFFFFFFF),
         vec(32'd0, 32'd1, 32'd0, 32'd0), 0, "R7 neg sat lane3", "R8 set lane3");
    step(0, '0, '0, '0, 1, "R10 idle", "R9 clear");
    // R6 positive sat lane 3 alone, R7 negative sat lane 1 alone
    step(1, mk(5, 0, 0), vec(32'd0, 32'd0, 32'h40000000, 32'h40000000),
         vec(32'd0, 32'd0, 32'd0, 32'd0), 0, "R6 pos sat lane3", "R8 set lane3");
    step(0, '0, '0, '0, 1, "R10 idle", "R9 clear");
    step(1, mk(6, 0, 0), vec(32'h80000000, 32'hC0000000, 32'd1, 32'd2),
         vec(32'd0, 32'hC0000000, 32'd0, 32'd3), 0, "R7 neg sat lane1", "R8 set lane1");
    // R9 clear wins over simultaneous set; R6 R7 worst cases both lanes
    step(1, mk(8, 0, 0), vec(32'h7FFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h80000000),
         vec(32'd0, 32'h7FFFFFFF, 32'd0, 32'h80000000), 1, "R6 R7 worst both", "R9 clear priority");
    step(1, mk(10, 0, 0), vec(32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF),
         vec(32'd0, 32'h7FFFFFFF, 32'd0, 32'h7FFFFFFF), 0, "R6 pos sat both", "R8 set both");
    step(0, '0, '0, '0, 1, "R10 idle", "R9 clear");
    step(1, mk(11, 0, 0), vec(32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000),
         vec(32'd0, 32'h80000000, 32'd0, 32'h80000000), 0, "R7 neg sat both", "R8 set both");
    // R11 reset mid-run
    rst = 1'b1;
    @(posedge clk);
    m_en = 1'b0; m_idx = '0; m_data = '0; m_sat = 1'b0;
    @(negedge clk);
    compare("R11 reset data", "R11 reset sat");
    rst = 1'b0;
    step(1, mk(12, 0, 0), vec(32'd10, 32'd20, 32'd30, 32'd40),
         vec(32'd0, 32'd1, 32'd0, 32'd2), 0, "R3 R4 R5 after reset", "R8 no sat");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule